// File: doc/BRIEF.md
# Retention-Ordered Way Placement Controller

This block decides where a new line goes in one set of a four-way cache whose physical ways hold data for different lengths of time. A configuration register, loaded once after the ways have been characterised, gives the physical ways in order from the longest-holding to the shortest-holding. It also marks each way that cannot be used at all. In the default placement mode a fill always lands in the longest-holding live way. Every resident line first steps one place toward the shorter-holding end, and the line in the shortest-holding live way leaves the set.

The controller does not touch data. It drives a per-destination source select for the way multiplexers, a one-hot write enable and a beat counter. The data path then copies a line one beat per cycle. A second mode ignores the ranking and replaces the oldest live way by 2-bit per-way age counters. In both modes an unusable way is never chosen. A set with no usable way rejects the fill.

Top module: `retention_place_ctrl`

## Requirements
- R1: After a synchronous reset, busy, fill_ack, fill_reject, evict_valid and move_valid are low and mux_we is zero. The configuration is the identity ranking (rank r names way r), no way is marked dead, the mode is ranked placement, and way i has age i.
- R2: The ranking is loaded from cfg_order, where bits [2r+1:2r] hold the physical way of rank r and rank 0 holds longest. In ranked mode with two or more live ways, an accepted fill raises evict_valid for exactly the first cycle after acceptance. evict_way names the lowest-ranked (shortest-holding) live way.
- R3: Moves run from the short end toward the long end. For live ways L0..Lk-1 in rank order, the order is Lk-2 into Lk-1, then Lk-3 into Lk-2, and so on up to L0 into L1. Each move lasts BEATS_PER_LINE cycles with move_beat counting 0 upward. During a move, mux_we is one-hot on the destination way, and the 2-bit field of mux_sel at bits [2d+1:2d] for destination d holds the source way.
- R4: busy and move_valid stay high in every move cycle. In the cycle after the last beat, fill_ack pulses with fill_way equal to the highest-ranked live way, and busy is low.
- R5: While busy, fill_req and cfg_we have no effect. No further fill is accepted and the configuration used afterwards is unchanged.
- R6: In ranked mode with exactly one live way, fill_ack and evict_valid both pulse in the first cycle after acceptance and name that way. busy stays low.
- R7: A way marked dead in cfg_dead (bit i for way i) is never named by fill_way or evict_way and never receives a write enable.
- R8: If every way is dead, a fill produces a one-cycle fill_reject in the first cycle after acceptance, with no ack, no eviction and no move.
- R9: With cfg_lru_mode set, a fill is answered in the first cycle after acceptance. fill_ack and evict_valid both name the live way with the largest age. A fill in this mode, or any hit, sets the touched way's age to 0 and increments every way whose age was below it.
- R10: Outside move cycles, mux_we is zero and each mux_sel field selects its own way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load ranking, dead mask and mode |
| cfg_order | input | NUM_WAYS*WAY_W | Physical way per rank, rank 0 longest-holding |
| cfg_dead | input | NUM_WAYS | Per-way unusable flag |
| cfg_lru_mode | input | 1 | 1 selects age-based replacement |
| fill_req | input | 1 | Request to allocate a new line |
| hit_valid | input | 1 | A hit occurred, refresh that way's age |
| hit_way | input | WAY_W | Way that hit |
| busy | output | 1 | Shift sequence in progress |
| fill_ack | output | 1 | New line may be written to fill_way |
| fill_reject | output | 1 | Fill not allocated, no live way |
| fill_way | output | WAY_W | Destination of the new line |
| evict_valid | output | 1 | A line leaves the set |
| evict_way | output | WAY_W | Way whose line leaves |
| move_valid | output | 1 | A beat copy is commanded this cycle |
| move_beat | output | BEAT_W | Beat index of the current copy |
| mux_we | output | NUM_WAYS | One-hot write enable per destination way |
| mux_sel | output | NUM_WAYS*WAY_W | Source way select per destination way |

## Verification
The bench builds the controller with four ways and two beats per line, which keeps every shift sequence short. Because of this, all 24 rank orders can be combined with all 16 dead masks in ranked mode. That covers every live count from zero to four, and so every chain of moves the sequencer can produce. The same small set then runs the age-based mode over every dead mask with interleaved hits, so the victim choice is checked against all age permutations the sequence reaches. A write of the configuration during a shift is also checked for having no effect.

// File: rtl/rplc_pkg.sv
package rplc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } rplc_state_e;

endpackage

// File: rtl/rplc_cfg_reg.sv
module rplc_cfg_reg #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      lock,
  input  logic [NUM_WAYS*WAY_W-1:0] wr_order,
  input  logic [NUM_WAYS-1:0]       wr_dead,
  input  logic                      wr_lru,
  output logic [NUM_WAYS*WAY_W-1:0] order_q,
  output logic [NUM_WAYS-1:0]       dead_q,
  output logic                      lru_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_WAYS; r++) begin
        order_q[r*WAY_W +: WAY_W] <= WAY_W'(r);
      end
      dead_q <= '0;
      lru_q  <= 1'b0;
    end else if (wr_en && !lock) begin
      order_q <= wr_order;
      dead_q  <= wr_dead;
      lru_q   <= wr_lru;
    end
  end

endmodule

// File: rtl/rplc_live_rank.sv
module rplc_live_rank #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic [NUM_WAYS*WAY_W-1:0] order,
  input  logic [NUM_WAYS-1:0]       dead,
  output logic [NUM_WAYS*WAY_W-1:0] live_list,
  output logic [CNT_W-1:0]          live_cnt
);

  // Compacts the ranking: entry i is the i-th live way, longest first.
  always_comb begin
    live_list = '0;
    live_cnt  = '0;
    for (int r = 0; r < NUM_WAYS; r++) begin
      if (!dead[order[r*WAY_W +: WAY_W]]) begin
        live_list[int'(live_cnt)*WAY_W +: WAY_W] = order[r*WAY_W +: WAY_W];
        live_cnt = live_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rplc_age_lru.sv
module rplc_age_lru #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                touch_en,
  input  logic [WAY_W-1:0]    touch_way,
  input  logic [NUM_WAYS-1:0] dead,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_ok
);

  logic [WAY_W-1:0] age_q [NUM_WAYS];
  logic [WAY_W-1:0] best_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NUM_WAYS; j++) begin
        age_q[j] <= WAY_W'(j);
      end
    end else if (touch_en) begin
      for (int j = 0; j < NUM_WAYS; j++) begin
        if (WAY_W'(j) == touch_way) begin
          age_q[j] <= '0;
        end else if (age_q[j] < age_q[touch_way]) begin
          age_q[j] <= age_q[j] + WAY_W'(1);
        end
      end
    end
  end

  always_comb begin
    victim_way = '0;
    victim_ok  = 1'b0;
    best_age   = '0;
    for (int j = 0; j < NUM_WAYS; j++) begin
      if (!dead[j] && (!victim_ok || age_q[j] > best_age)) begin
        victim_way = WAY_W'(j);
        best_age   = age_q[j];
        victim_ok  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/retention_place_ctrl.sv
module retention_place_ctrl #(
  parameter  int NUM_WAYS       = 4,
  parameter  int BEATS_PER_LINE = 8,
  localparam int WAY_W          = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int BEAT_W         = (BEATS_PER_LINE > 1) ? $clog2(BEATS_PER_LINE) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [NUM_WAYS*WAY_W-1:0] cfg_order,
  input  logic [NUM_WAYS-1:0]       cfg_dead,
  input  logic                      cfg_lru_mode,
  input  logic                      fill_req,
  input  logic                      hit_valid,
  input  logic [WAY_W-1:0]          hit_way,
  output logic                      busy,
  output logic                      fill_ack,
  output logic                      fill_reject,
  output logic [WAY_W-1:0]          fill_way,
  output logic                      evict_valid,
  output logic [WAY_W-1:0]          evict_way,
  output logic                      move_valid,
  output logic [BEAT_W-1:0]         move_beat,
  output logic [NUM_WAYS-1:0]       mux_we,
  output logic [NUM_WAYS*WAY_W-1:0] mux_sel
);
  import rplc_pkg::*;

  localparam int CNT_W = $clog2(NUM_WAYS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS_PER_LINE - 1);

  rplc_state_e               state_q;
  logic [WAY_W-1:0]          pair_q;
  logic [NUM_WAYS*WAY_W-1:0] cfg_order_q;
  logic [NUM_WAYS-1:0]       cfg_dead_q;
  logic                      cfg_lru_q;
  logic [NUM_WAYS*WAY_W-1:0] live_list;
  logic [CNT_W-1:0]          live_cnt;
  logic [NUM_WAYS*WAY_W-1:0] ident_sel;
  logic [WAY_W-1:0]          victim_way;
  logic                      victim_ok;
  logic                      accept;
  logic                      lru_fill;
  logic                      touch_en;
  logic [WAY_W-1:0]          touch_way;

  function automatic logic [WAY_W-1:0] entry(input logic [NUM_WAYS*WAY_W-1:0] lst,
                                             input int idx);
    return lst[idx*WAY_W +: WAY_W];
  endfunction

  function automatic logic [NUM_WAYS-1:0] onehot(input logic [WAY_W-1:0] w);
    logic [NUM_WAYS-1:0] v;
    v    = '0;
    v[w] = 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_WAYS*WAY_W-1:0] route(input logic [NUM_WAYS*WAY_W-1:0] base,
                                                      input logic [WAY_W-1:0] dst,
                                                      input logic [WAY_W-1:0] src);
    logic [NUM_WAYS*WAY_W-1:0] v;
    v = base;
    v[int'(dst)*WAY_W +: WAY_W] = src;
    return v;
  endfunction

  always_comb begin
    for (int r = 0; r < NUM_WAYS; r++) begin
      ident_sel[r*WAY_W +: WAY_W] = WAY_W'(r);
    end
  end

  rplc_cfg_reg #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) i_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .lock     (state_q == ST_MOVE),
    .wr_order (cfg_order),
    .wr_dead  (cfg_dead),
    .wr_lru   (cfg_lru_mode),
    .order_q  (cfg_order_q),
    .dead_q   (cfg_dead_q),
    .lru_q    (cfg_lru_q)
  );

  rplc_live_rank #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) i_rank (
    .order     (cfg_order_q),
    .dead      (cfg_dead_q),
    .live_list (live_list),
    .live_cnt  (live_cnt)
  );

  assign accept    = (state_q == ST_IDLE) && fill_req;
  assign lru_fill  = accept && cfg_lru_q && victim_ok;
  assign touch_en  = lru_fill || hit_valid;
  assign touch_way = lru_fill ? victim_way : hit_way;

  rplc_age_lru #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) i_age (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .dead       (cfg_dead_q),
    .victim_way (victim_way),
    .victim_ok  (victim_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pair_q      <= '0;
      busy        <= 1'b0;
      fill_ack    <= 1'b0;
      fill_reject <= 1'b0;
      fill_way    <= '0;
      evict_valid <= 1'b0;
      evict_way   <= '0;
      move_valid  <= 1'b0;
      move_beat   <= '0;
      mux_we      <= '0;
      mux_sel     <= ident_sel;
    end else begin
      fill_ack    <= 1'b0;
      fill_reject <= 1'b0;
      evict_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          busy       <= 1'b0;
          move_valid <= 1'b0;
          mux_we     <= '0;
          mux_sel    <= ident_sel;
          if (accept) begin
            if (live_cnt == '0) begin
              fill_reject <= 1'b1;
            end else if (cfg_lru_q) begin
              fill_ack    <= 1'b1;
              evict_valid <= 1'b1;
              fill_way    <= victim_way;
              evict_way   <= victim_way;
            end else if (live_cnt == CNT_W'(1)) begin
              fill_ack    <= 1'b1;
              evict_valid <= 1'b1;
              fill_way    <= entry(live_list, 0);
              evict_way   <= entry(live_list, 0);
            end else begin
              state_q     <= ST_MOVE;
              busy        <= 1'b1;
              evict_valid <= 1'b1;
              evict_way   <= entry(live_list, int'(live_cnt) - 1);
              pair_q      <= WAY_W'(int'(live_cnt) - 2);
              move_valid  <= 1'b1;
              move_beat   <= '0;
              mux_we      <= onehot(entry(live_list, int'(live_cnt) - 1));
              mux_sel     <= route(ident_sel, entry(live_list, int'(live_cnt) - 1),
                                   entry(live_list, int'(live_cnt) - 2));
            end
          end
        end
        ST_MOVE: begin
          if (move_beat == LAST_BEAT) begin
            if (pair_q == '0) begin
              state_q    <= ST_IDLE;
              busy       <= 1'b0;
              move_valid <= 1'b0;
              move_beat  <= '0;
              mux_we     <= '0;
              mux_sel    <= ident_sel;
              fill_ack   <= 1'b1;
              fill_way   <= entry(live_list, 0);
            end else begin
              pair_q    <= pair_q - WAY_W'(1);
              move_beat <= '0;
              mux_we    <= onehot(entry(live_list, int'(pair_q)));
              mux_sel   <= route(ident_sel, entry(live_list, int'(pair_q)),
                                 entry(live_list, int'(pair_q) - 1));
            end
          end else begin
            move_beat <= move_beat + BEAT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rplc_chk.sv
module rplc_chk #(
  parameter  int NUM_WAYS       = 4,
  parameter  int BEATS_PER_LINE = 8,
  localparam int WAY_W          = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int BEAT_W         = (BEATS_PER_LINE > 1) ? $clog2(BEATS_PER_LINE) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_WAYS-1:0]       dead,
  input logic                      busy,
  input logic                      fill_ack,
  input logic                      fill_reject,
  input logic [WAY_W-1:0]          fill_way,
  input logic                      evict_valid,
  input logic [WAY_W-1:0]          evict_way,
  input logic                      move_valid,
  input logic [BEAT_W-1:0]         move_beat,
  input logic [NUM_WAYS-1:0]       mux_we,
  input logic [NUM_WAYS*WAY_W-1:0] mux_sel
);

  logic [NUM_WAYS-1:0]       dead_d;
  logic [NUM_WAYS*WAY_W-1:0] ident;

  always_ff @(posedge clk) begin
    dead_d <= dead;
  end

  always_comb begin
    for (int r = 0; r < NUM_WAYS; r++) begin
      ident[r*WAY_W +: WAY_W] = WAY_W'(r);
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mux_we)); // R3

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (move_valid && $past(move_valid) && move_beat != '0) |->
      move_beat == BEAT_W'($past(move_beat) + 1'b1)); // R3

  AST_MOVE_WE: assert property (@(posedge clk) disable iff (rst)
    move_valid |-> $countones(mux_we) == 1); // R3

  AST_MOVE_BUSY: assert property (@(posedge clk) disable iff (rst)
    move_valid |-> busy); // R4

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    fill_ack |-> !busy); // R4

  AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && busy) |-> (move_valid && move_beat == '0)); // R2

  AST_NO_DEAD_FILL: assert property (@(posedge clk) disable iff (rst)
    fill_ack |-> !dead_d[fill_way]); // R7

  AST_NO_DEAD_EVICT: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> !dead_d[evict_way]); // R7

  AST_NO_DEAD_WE: assert property (@(posedge clk) disable iff (rst)
    (mux_we & dead_d) == '0); // R7

  AST_REJECT_ALONE: assert property (@(posedge clk) disable iff (rst)
    fill_reject |-> (!fill_ack && !evict_valid && !move_valid)); // R8

  AST_IDLE_MUX: assert property (@(posedge clk) disable iff (rst)
    !move_valid |-> (mux_we == '0 && mux_sel == ident)); // R10

endmodule

bind retention_place_ctrl rplc_chk #(
  .NUM_WAYS       (NUM_WAYS),
  .BEATS_PER_LINE (BEATS_PER_LINE)
) i_rplc_chk (
  .clk         (clk),
  .rst         (rst),
  .dead        (cfg_dead_q),
  .busy        (busy),
  .fill_ack    (fill_ack),
  .fill_reject (fill_reject),
  .fill_way    (fill_way),
  .evict_valid (evict_valid),
  .evict_way   (evict_way),
  .move_valid  (move_valid),
  .move_beat   (move_beat),
  .mux_we      (mux_we),
  .mux_sel     (mux_sel)
);

// File: tb/test_retention_place_ctrl.sv
`timescale 1ns/1ps
module test_retention_place_ctrl;

  localparam int NW = 4;
  localparam int NB = 2;
  localparam int WW = 2;
  localparam int BW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [NW*WW-1:0] cfg_order = 8'hE4;
  logic [NW-1:0] cfg_dead = '0;
  logic          cfg_lru_mode = 1'b0;
  logic          fill_req = 1'b0;
  logic          hit_valid = 1'b0;
  logic [WW-1:0] hit_way = '0;
  logic          busy, fill_ack, fill_reject, evict_valid, move_valid;
  logic [WW-1:0] fill_way, evict_way;
  logic [BW-1:0] move_beat;
  logic [NW-1:0] mux_we;
  logic [NW*WW-1:0] mux_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int m_order [NW];
  int m_dead  [NW];
  int m_lru;
  int m_age   [NW];
  int m_list  [NW];
  int m_cnt;

  always #2.5 clk = ~clk;

  retention_place_ctrl #(.NUM_WAYS(NW), .BEATS_PER_LINE(NB)) i_retention_place_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_order(cfg_order), .cfg_dead(cfg_dead),
    .cfg_lru_mode(cfg_lru_mode), .fill_req(fill_req), .hit_valid(hit_valid), .hit_way(hit_way),
    .busy(busy), .fill_ack(fill_ack), .fill_reject(fill_reject), .fill_way(fill_way),
    .evict_valid(evict_valid), .evict_way(evict_way), .move_valid(move_valid),
    .move_beat(move_beat), .mux_we(mux_we), .mux_sel(mux_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build_list();
    m_cnt = 0;
    for (int r = 0; r < NW; r++) begin
      if (m_dead[m_order[r]] == 0) begin
        m_list[m_cnt] = m_order[r];
        m_cnt++;
      end
    end
  endtask

  function automatic int model_victim();
    int v = -1;
    for (int j = 0; j < NW; j++) begin
      if (m_dead[j] == 0 && (v < 0 || m_age[j] > m_age[v])) v = j;
    end
    return v;
  endfunction

  task automatic model_touch(input int w);
    int a = m_age[w];
    for (int j = 0; j < NW; j++) begin
      if (j == w) m_age[j] = 0;
      else if (m_age[j] < a) m_age[j] = m_age[j] + 1;
    end
  endtask

  task automatic cfg_write(input logic [7:0] ordv, input logic [3:0] deadv, input logic lru);
    @(negedge clk);
    cfg_we = 1'b1; cfg_order = ordv; cfg_dead = deadv; cfg_lru_mode = lru;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int r = 0; r < NW; r++) begin
      m_order[r] = int'(ordv[r*2 +: 2]);
      m_dead[r]  = int'(deadv[r]);
    end
    m_lru = int'(lru);
  endtask

  task automatic do_hit(input int w);
    @(negedge clk);
    hit_valid = 1'b1; hit_way = WW'(w);
    @(negedge clk);
    hit_valid = 1'b0;
    model_touch(w);
    chk("R9 hit gives no ack", int'(fill_ack), 0);
    chk("R9 hit gives no evict", int'(evict_valid), 0);
  endtask

  task automatic do_fill();
    int w;
    logic [7:0] exp_sel;
    bit first;
    build_list();
    @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    if (m_cnt == 0) begin
      fill_req = 1'b0;
      chk("R8 reject", int'(fill_reject), 1);
      chk("R8 no ack", int'(fill_ack), 0);
      chk("R8 no evict", int'(evict_valid), 0);
      chk("R8 no move", int'(move_valid), 0);
    end else if (m_lru != 0 || m_cnt == 1) begin
      fill_req = 1'b0;
      w = (m_lru != 0) ? model_victim() : m_list[0];
      if (m_lru != 0) begin
        chk("R9 ack", int'(fill_ack), 1);
        chk("R9 fill way", int'(fill_way), w);
        chk("R9 evict way", int'(evict_way), w);
        model_touch(w);
      end else begin
        chk("R6 ack", int'(fill_ack), 1);
        chk("R6 evict", int'(evict_valid), 1);
        chk("R6 fill way", int'(fill_way), w);
        chk("R6 evict way", int'(evict_way), w);
        chk("R6 not busy", int'(busy), 0);
      end
      chk("R7 fill way live", m_dead[fill_way], 0);
      chk("R10 no write", int'(mux_we), 0);
    end else begin
      chk("R2 evict", int'(evict_valid), 1);
      chk("R2 evict way", int'(evict_way), m_list[m_cnt-1]);
      chk("R7 evict way live", m_dead[evict_way], 0);
      first = 1;
      for (int p = m_cnt - 2; p >= 0; p--) begin
        for (int b = 0; b < NB; b++) begin
          if (!first) begin
            @(negedge clk);
            chk("R2 single evict pulse", int'(evict_valid), 0);
          end
          first = 0;
          exp_sel = 8'hE4;
          exp_sel[m_list[p+1]*2 +: 2] = 2'(m_list[p]);
          chk("R4 busy", int'(busy), 1);
          chk("R4 move valid", int'(move_valid), 1);
          chk("R3 beat", int'(move_beat), b);
          chk("R3 write enable", int'(mux_we), 1 << m_list[p+1]);
          chk("R3 mux select", int'(mux_sel), int'(exp_sel));
          chk("R5 no ack while busy", int'(fill_ack), 0);
        end
      end
      @(negedge clk);
      fill_req = 1'b0;
      chk("R4 ack", int'(fill_ack), 1);
      chk("R4 fill way", int'(fill_way), m_list[0]);
      chk("R4 busy low", int'(busy), 0);
      chk("R10 no write", int'(mux_we), 0);
      chk("R10 identity select", int'(mux_sel), 'hE4);
    end
    @(negedge clk);
    chk("R5 no second ack", int'(fill_ack), 0);
    chk("R5 no second evict", int'(evict_valid), 0);
    chk("R8 no stray reject", int'(fill_reject), 0);
  endtask

  task automatic perm_to_order(input int n, output logic [7:0] ordv);
    int avail [NW];
    int left, f, idx, k;
    for (int i = 0; i < NW; i++) avail[i] = i;
    left = NW;
    k = n;
    for (int r = 0; r < NW; r++) begin
      f = 1;
      for (int i = 2; i < left; i++) f = f * i;
      idx = k / f;
      k = k % f;
      ordv[r*2 +: 2] = 2'(avail[idx]);
      for (int i = idx; i < NW - 1; i++) avail[i] = avail[i+1];
      left--;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ordv;
    int seen;
    for (int r = 0; r < NW; r++) begin
      m_order[r] = r; m_dead[r] = 0; m_age[r] = r;
    end
    m_lru = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ack", int'(fill_ack), 0);
    chk("R1 reject", int'(fill_reject), 0);
    chk("R1 evict", int'(evict_valid), 0);
    chk("R1 move", int'(move_valid), 0);
    chk("R1 write enable", int'(mux_we), 0);
    chk("R10 reset select", int'(mux_sel), 'hE4);
    // R1: default ranking and mode seen through a fill
    do_fill();

    for (int n = 0; n < 24; n++) begin
      perm_to_order(n, ordv);
      for (int d = 0; d < 16; d++) begin
        cfg_write(ordv, 4'(d), 1'b0);
        do_fill();
      end
    end

    // R5: configuration write during a shift is ignored
    cfg_write(8'h1B, 4'h0, 1'b0);
    @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    chk("R5 busy after accept", int'(busy), 1);
    cfg_we = 1'b1; cfg_dead = 4'hF; cfg_lru_mode = 1'b1; cfg_order = 8'hE4;
    @(negedge clk);
    cfg_we = 1'b0;
    seen = 0;
    for (int i = 0; i < 20 && seen == 0; i++) begin
      if (fill_ack) seen = 1;
      else @(negedge clk);
    end
    chk("R5 shift completes", seen, 1);
    do_fill();

    // R9: age-based replacement across all dead masks with hits
    for (int d = 0; d < 16; d++) begin
      cfg_write((d % 3 == 0) ? 8'h4E : 8'hE4, 4'(d), 1'b1);
      for (int k = 0; k < 6; k++) begin
        if (k % 2 == 1) do_hit((d + k) % NW);
        do_fill();
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule